// File: doc/BRIEF.md
# SPI Master Burst Engine with Register Control

This block is a memory-mapped SPI master. Software writes a control word that sets the word length, the number of words in a burst, the clock phase, the resting level of the serial clock, which of four chip selects to drive and the active level of each select. It then loads words into a 32-entry transmit FIFO and writes the control word again with the start bit set. The engine shifts the whole burst out and in without further help and pushes each received word into a 32-entry receive FIFO, which software drains through a data register.

A status register shows whether the engine is busy, whether the burst has finished, whether each FIFO is full or empty, and four sticky error flags. Writing ones to chosen status bits acknowledges completion or empties a FIFO. The serial clock half-period is a fixed number of system clock cycles, set by a parameter.

Top module: `spim_burst`

Registers are selected by `bus_addr`: 0 = control (read/write), 1 = status, 2 = transmit data (write pushes), 3 = receive data (a read with `bus_rd` pops). Reads return data combinationally from `bus_addr`.

## Requirements
- R1: Control bits [4:0] hold the word length minus one (1 to 32 bits). Each received word is stored right-aligned and its bits above the word length read as zero.
- R2: Control bits [9:5] hold the burst word count minus one (1 to 32 words). A burst makes exactly 2 x length x count serial clock transitions.
- R3: Each transmit word is taken right-aligned from its FIFO entry and shifted most significant bit first, starting at bit (length-1). With `spi_miso` tied to the inverse of `spi_mosi`, each received word equals the inverted transmit word masked to the word length.
- R4: Control bit [10] selects the clock phase. With 0, `spi_mosi` changes only on trailing clock edges and input is sampled on leading edges. With 1, `spi_mosi` changes only on leading edges and input is sampled on trailing edges.
- R5: Control bits [12:11] set the idle clock level: code 0 is low, code 1 is high. `spi_sclk` rests at that level outside a burst.
- R6: Control bits [14:13] select one chip select and bits [18:15] give a polarity for each select (1 = active high, 0 = active low). The selected output is asserted from the start bit until one half-period after the last clock edge, and it leads the first edge by one half-period. Every other select holds its inactive level.
- R7: With control bit [19] clear, the engine shifts zeros and leaves the transmit FIFO untouched. With control bit [20] clear, no received word enters the receive FIFO.
- R8: Writing control bit [31] starts a burst, and the start bit is ignored while busy. Status bit [0] (busy) is high until the trailing half-period ends. Status bit [1] (ready) sets when the last word completes, so it reads set together with busy for one half-period. Ready then stays set until a 1 is written to it.
- R9: Writing 1 to status bit [10] empties the transmit FIFO and clears its overflow and underflow flags. Writing 1 to status bit [11] does the same for the receive FIFO and its flags.
- R10: Status bits [2] and [3] report transmit full and empty, and bits [4] and [5] report receive full and empty. A write to a full transmit FIFO is dropped and sets the sticky transmit overflow flag, bit [6].
- R11: If the transmit FIFO is empty when a word is needed and transmit is enabled, a zero word is shifted and sticky bit [7] sets. A word arriving at a full receive FIFO is dropped and sets sticky bit [8]. A read of an empty receive FIFO returns zero and sets sticky bit [9].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive FIFO at address 3) |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 4 | Chip select outputs, one per device |

## Verification
The serial input is tied to the inverted serial output, so each received word reveals the data order, the masking and the word framing at once. Bursts are run at word lengths of 1, 5, 8, 13 and 32 bits, at several word counts up to the maximum, and in both clock phases and both idle levels. Counting clock transitions separates the length and count fields. Recording the edge on which the output data moves separates the two phases. Dedicated runs fill the transmit FIFO past full, disable transmit or receive, starve the transmitter, overfill the receiver and read it empty, and each one is followed by a flush so that the sticky flags can be seen to set and then clear.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int DATA_W  = 32;
    localparam int NUM_CS  = 4;
    localparam int LEN_W   = 5;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_TXD  = 2'd2;
    localparam logic [1:0] ADDR_RXD  = 2'd3;

    typedef struct packed {
        logic              rx_on;
        logic              tx_on;
        logic [NUM_CS-1:0] cs_pol;
        logic [1:0]        cs_sel;
        logic [1:0]        idle_code;
        logic              late_phase;
        logic [LEN_W-1:0]  words_m1;
        logic [LEN_W-1:0]  bits_m1;
    } spim_cfg_t;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_RUN   = 2'd1,
        ENG_TRAIL = 2'd2
    } eng_state_e;

    function automatic spim_cfg_t cfg_unpack(input logic [DATA_W-1:0] w);
        spim_cfg_t c;
        c.bits_m1    = w[4:0];
        c.words_m1   = w[9:5];
        c.late_phase = w[10];
        c.idle_code  = w[12:11];
        c.cs_sel     = w[14:13];
        c.cs_pol     = w[18:15];
        c.tx_on      = w[19];
        c.rx_on      = w[20];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_pack(input spim_cfg_t c);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[4:0]   = c.bits_m1;
        w[9:5]   = c.words_m1;
        w[10]    = c.late_phase;
        w[12:11] = c.idle_code;
        w[14:13] = c.cs_sel;
        w[18:15] = c.cs_pol;
        w[19]    = c.tx_on;
        w[20]    = c.rx_on;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] len_mask(input logic [LEN_W-1:0] m1);
        return {DATA_W{1'b1}} >> (5'd31 - m1);
    endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;
    logic             do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    assert_count_bound_R10: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    assert_full_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (full && !pop && !flush) |=> full);

endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  spim_cfg_t         cfg,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              tx_empty,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_word,
    output logic              done,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);
    localparam int HW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    eng_state_e        state;
    logic [HW-1:0]     hcnt;
    logic              sclk_q, lead_next;
    logic [LEN_W-1:0]  bcnt, wcnt;
    logic [DATA_W-1:0] tx_sh, rx_sh, rx_next, load_val;
    logic              edge_ev, is_lead, is_trail, last_bit, last_word;
    logic              sample_now, shift_now, load_word, word_end;

    always_comb begin
        edge_ev    = (state == ENG_RUN) && (hcnt == HW'(HALF_DIV - 1));
        is_lead    = edge_ev && lead_next;
        is_trail   = edge_ev && !lead_next;
        last_bit   = (bcnt == cfg.bits_m1);
        last_word  = (wcnt == cfg.words_m1);
        word_end   = is_trail && last_bit;
        rx_next    = {rx_sh[DATA_W-2:0], miso};
        sample_now = cfg.late_phase ? is_trail : is_lead;
        if (cfg.late_phase) begin
            shift_now = is_lead && (bcnt != '0);
            load_word = (state == ENG_IDLE && go) ||
                        (is_lead && bcnt == '0 && wcnt != '0);
        end else begin
            shift_now = is_trail && !last_bit;
            load_word = (state == ENG_IDLE && go) || (word_end && !last_word);
        end
        load_val = (cfg.tx_on && !tx_empty) ? tx_word : '0;
    end

    assign tx_pop  = load_word && cfg.tx_on;
    assign rx_push = word_end && cfg.rx_on;
    assign rx_word = (cfg.late_phase ? rx_next : rx_sh) & len_mask(cfg.bits_m1);
    assign done    = word_end && last_word;
    assign busy    = (state != ENG_IDLE);
    assign sclk    = sclk_q;
    assign mosi    = tx_sh[cfg.bits_m1];

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ENG_IDLE;
            hcnt      <= '0;
            sclk_q    <= 1'b0;
            lead_next <= 1'b1;
            bcnt      <= '0;
            wcnt      <= '0;
            rx_sh     <= '0;
        end else begin
            case (state)
                ENG_IDLE: begin
                    sclk_q <= cfg.idle_code[0];
                    if (go) begin
                        state     <= ENG_RUN;
                        hcnt      <= '0;
                        lead_next <= 1'b1;
                        bcnt      <= '0;
                        wcnt      <= '0;
                        rx_sh     <= '0;
                    end
                end
                ENG_RUN: begin
                    hcnt <= edge_ev ? '0 : hcnt + 1'b1;
                    if (edge_ev) begin
                        sclk_q    <= ~sclk_q;
                        lead_next <= ~lead_next;
                    end
                    if (sample_now) rx_sh <= rx_next;
                    if (word_end) begin
                        bcnt  <= '0;
                        wcnt  <= wcnt + 1'b1;
                        rx_sh <= '0;
                        if (last_word) state <= ENG_TRAIL;
                    end else if (is_trail) begin
                        bcnt <= bcnt + 1'b1;
                    end
                end
                ENG_TRAIL: begin
                    hcnt <= hcnt + 1'b1;
                    if (hcnt == HW'(HALF_DIV - 1)) begin
                        state <= ENG_IDLE;
                        hcnt  <= '0;
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            tx_sh <= '0;
        else if (load_word) tx_sh <= load_val;
        else if (shift_now) tx_sh <= tx_sh << 1;
    end

    assert_bit_in_range_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ENG_RUN) |-> (bcnt <= cfg.bits_m1));

    assert_clock_rests_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ENG_TRAIL) |-> (sclk_q == cfg.idle_code[0]));

    assert_no_edge_outside_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(state) != ENG_RUN && state != ENG_RUN && $past(state) != ENG_IDLE)
            |-> $stable(sclk_q));

endmodule

// File: rtl/spim_burst.sv
module spim_burst
    import spim_pkg::*;
#(
    parameter int HALF_DIV   = 2,
    parameter int FIFO_DEPTH = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic [3:0]  spi_cs
);
    spim_cfg_t         cfg;
    logic              wr_ctrl, wr_stat, wr_txd, rd_rxd;
    logic              go, busy, done, tx_pop, rx_push;
    logic              flush_tx, flush_rx, ack_ready;
    logic              ready, tx_ovf, tx_unf, rx_ovf, rx_unf;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [DATA_W-1:0] tx_dout, rx_dout, rx_word;

    assign wr_ctrl   = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_stat   = bus_wr && (bus_addr == ADDR_STAT);
    assign wr_txd    = bus_wr && (bus_addr == ADDR_TXD);
    assign rd_rxd    = bus_rd && (bus_addr == ADDR_RXD);
    assign go        = wr_ctrl && bus_wdata[31] && !busy;
    assign flush_tx  = wr_stat && bus_wdata[10];
    assign flush_rx  = wr_stat && bus_wdata[11];
    assign ack_ready = wr_stat && bus_wdata[1];

    always_ff @(posedge clk) begin
        if (rst)          cfg <= '0;
        else if (wr_ctrl) cfg <= cfg_unpack(bus_wdata);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ready  <= 1'b0;
            tx_ovf <= 1'b0;
            tx_unf <= 1'b0;
            rx_ovf <= 1'b0;
            rx_unf <= 1'b0;
        end else begin
            if (done)           ready <= 1'b1;
            else if (ack_ready) ready <= 1'b0;
            if (flush_tx) begin
                tx_ovf <= 1'b0;
                tx_unf <= 1'b0;
            end else begin
                if (wr_txd && tx_full)  tx_ovf <= 1'b1;
                if (tx_pop && tx_empty) tx_unf <= 1'b1;
            end
            if (flush_rx) begin
                rx_ovf <= 1'b0;
                rx_unf <= 1'b0;
            end else begin
                if (rx_push && rx_full) rx_ovf <= 1'b1;
                if (rd_rxd && rx_empty) rx_unf <= 1'b1;
            end
        end
    end

    spim_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .flush(flush_tx),
        .push(wr_txd), .din(bus_wdata),
        .pop(tx_pop), .dout(tx_dout),
        .full(tx_full), .empty(tx_empty)
    );

    spim_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .flush(flush_rx),
        .push(rx_push), .din(rx_word),
        .pop(rd_rxd), .dout(rx_dout),
        .full(rx_full), .empty(rx_empty)
    );

    spim_engine #(.HALF_DIV(HALF_DIV)) u_eng (
        .clk(clk), .rst(rst), .go(go), .cfg(cfg),
        .tx_word(tx_dout), .tx_empty(tx_empty), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_word(rx_word),
        .done(done), .busy(busy),
        .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso)
    );

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign spi_cs[i] = (busy && cfg.cs_sel == 2'(i)) ? cfg.cs_pol[i] : ~cfg.cs_pol[i];
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTRL: bus_rdata = cfg_pack(cfg);
            ADDR_STAT: bus_rdata = {22'd0, rx_unf, rx_ovf, tx_unf, tx_ovf,
                                    rx_empty, rx_full, tx_empty, tx_full, ready, busy};
            ADDR_RXD:  bus_rdata = rx_empty ? '0 : rx_dout;
            default:   bus_rdata = '0;
        endcase
    end

    assert_ready_hold_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(ready) && !$past(ack_ready)) |-> ready);

    assert_ready_on_done_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> (ready && busy));

    assert_one_select_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(spi_cs ^ ~cfg.cs_pol));

    assert_txovf_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(tx_ovf) && !$past(flush_tx)) |-> tx_ovf);

    assert_rxunf_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        ($past(rx_unf) && !$past(flush_rx)) |-> rx_unf);

endmodule

// File: tb/sim_spim_burst.sv
module sim_spim_burst;
    localparam int DIV = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sclk, spi_mosi, spi_miso;
    logic [3:0]  spi_cs;

    assign spi_miso = ~spi_mosi;

    spim_burst #(.HALF_DIV(DIV), .FIFO_DEPTH(32)) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs(spi_cs)
    );

    always #10 clk = ~clk;

    int n_checks = 0, n_fail = 0;
    logic [31:0] expq[$];

    // monitor state
    int  cyc = 0, tog_total = 0, bad_total = 0;
    int  cs_on_cyc = 0, cs_off_cyc = 0, first_tog = 0, last_tog = 0;
    logic first_pend = 0;
    logic prev_sclk = 0, prev_mosi = 0;
    logic [3:0] prev_cs = 4'hF, idle_pat = 4'hF, act_pat = 4'hF;
    logic cur_idle = 0, cur_phase = 0;
    logic saw_both = 0;
    logic finished = 0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (!rst) begin
            if (spi_sclk != prev_sclk) begin
                tog_total <= tog_total + 1;
                last_tog  <= cyc;
                if (first_pend) begin
                    first_tog  <= cyc;
                    first_pend <= 0;
                end
            end
            if (spi_mosi != prev_mosi && prev_cs != idle_pat) begin
                if (spi_sclk == prev_sclk) bad_total <= bad_total + 1;
                else if ((spi_sclk != cur_idle) != cur_phase) bad_total <= bad_total + 1;
            end
            if (spi_cs != prev_cs) begin
                if (spi_cs == act_pat) begin
                    cs_on_cyc  <= cyc;
                    first_pend <= 1;
                end else begin
                    cs_off_cyc <= cyc;
                end
            end
        end
        prev_sclk <= spi_sclk;
        prev_mosi <= spi_mosi;
        prev_cs   <= spi_cs;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic pop, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = pop;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic logic [31:0] mk_ctrl(int nb, int nw, logic ph, logic [1:0] idle,
                                            logic [1:0] sel, logic [3:0] pol,
                                            logic txon, logic rxon, logic go);
        logic [31:0] w;
        w = '0;
        w[4:0] = 5'(nb - 1); w[9:5] = 5'(nw - 1); w[10] = ph; w[12:11] = idle;
        w[14:13] = sel; w[18:15] = pol; w[19] = txon; w[20] = rxon; w[31] = go;
        return w;
    endfunction

    function automatic logic [31:0] mask_of(int nb);
        return (nb >= 32) ? 32'hFFFF_FFFF : ((32'd1 << nb) - 1);
    endfunction

    function automatic logic [3:0] cs_pat(logic [3:0] pol, logic [1:0] sel, logic act);
        logic [3:0] p;
        for (int i = 0; i < 4; i++) p[i] = (act && sel == 2'(i)) ? pol[i] : ~pol[i];
        return p;
    endfunction

    // driver: pushes TX words and expected RX words into the scoreboard
    task automatic load_tx(int nw, int nb, logic [31:0] seed, logic expect_rx);
        for (int i = 0; i < nw; i++) begin
            logic [31:0] w;
            w = seed ^ (32'h1F3D5B79 * (i + 1));
            wr(2'd2, w);
            if (expect_rx) expq.push_back(~w & mask_of(nb));
        end
    endtask

    task automatic wait_ready();
        logic [31:0] s;
        saw_both = 0;
        s = 0;
        while (s[1] !== 1'b1) begin
            rd(2'd1, 1'b0, s);
            if (s[0] && s[1]) saw_both = 1;
        end
        while (s[0] === 1'b1) begin
            rd(2'd1, 1'b0, s);
        end
    endtask

    // monitor side of the scoreboard: drains RX and compares in order
    task automatic drain(input string tag);
        logic [31:0] s, d;
        rd(2'd1, 1'b0, s);
        while (s[5] == 1'b0) begin
            rd(2'd3, 1'b1, d);
            if (expq.size() == 0) check({tag, " extra rx word"}, d, 32'hDEAD_BEEF);
            else check(tag, d, expq.pop_front());
            rd(2'd1, 1'b0, s);
        end
        check({tag, " scoreboard empty"}, expq.size(), 0);
    endtask

    task automatic burst(input string tag, int nb, int nw, logic ph, logic [1:0] idle,
                         logic [1:0] sel, logic [3:0] pol, logic txon, logic rxon);
        int t0, b0;
        cur_idle  = idle[0];
        cur_phase = ph;
        idle_pat  = cs_pat(pol, sel, 1'b0);
        act_pat   = cs_pat(pol, sel, 1'b1);
        wr(2'd0, mk_ctrl(nb, nw, ph, idle, sel, pol, txon, rxon, 1'b0));
        @(negedge clk);
        @(negedge clk);
        check({tag, " R5 idle clock"}, spi_sclk, idle[0]);
        check({tag, " R6 idle selects"}, spi_cs, idle_pat);
        t0 = tog_total; b0 = bad_total;
        wr(2'd0, mk_ctrl(nb, nw, ph, idle, sel, pol, txon, rxon, 1'b1));
        check({tag, " R6 active select"}, spi_cs, act_pat);
        wait_ready();
        @(negedge clk);
        check({tag, " R2 clock edges"}, tog_total - t0, 2 * nb * nw);
        check({tag, " R4 data edge"}, bad_total - b0, 0);
        check({tag, " R6 lead gap"}, first_tog - cs_on_cyc, DIV);
        check({tag, " R6 trail gap"}, cs_off_cyc - last_tog, DIV);
        check({tag, " R5 clock rests"}, spi_sclk, idle[0]);
        check({tag, " R8 busy and ready overlap"}, saw_both, 1);
    endtask

    task automatic ack();
        logic [31:0] s;
        rd(2'd1, 1'b0, s);
        check("R8 ready held", s[1:0], 2'b10);
        wr(2'd1, 32'h2);
        rd(2'd1, 1'b0, s);
        check("R8 ready cleared", s[1:0], 2'b00);
    endtask

    initial begin
        logic [31:0] s, d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd(2'd1, 1'b0, s);
        check("reset status R10", s, 32'h28);
        check("reset clock R5", spi_sclk, 1'b0);
        check("reset selects R6", spi_cs, 4'hF);

        // R1 R3 R4: 8 bits, 4 words, phase 0, idle low
        load_tx(4, 8, 32'hA5C3_0F11, 1'b1);
        burst("b8x4 R3", 8, 4, 1'b0, 2'd0, 2'd1, 4'b0000, 1'b1, 1'b1);
        ack();
        drain("b8x4 R1 R3 data");

        // R4 R5 R6: 13 bits, 3 words, phase 1, idle high, active-high select 3
        load_tx(3, 13, 32'h0F0F_1234, 1'b1);
        burst("b13x3 R4", 13, 3, 1'b1, 2'd1, 2'd3, 4'b1001, 1'b1, 1'b1);
        ack();
        drain("b13x3 R4 data");

        // 1-bit words, phase 1, select 2
        load_tx(5, 1, 32'h5555_AAAB, 1'b1);
        burst("b1x5 R1", 1, 5, 1'b1, 2'd0, 2'd2, 4'b0100, 1'b1, 1'b1);
        ack();
        drain("b1x5 R1 data");

        // R10: fill TX past full; R2 max burst 32x32
        load_tx(32, 32, 32'hC001_D00D, 1'b1);
        rd(2'd1, 1'b0, s);
        check("R10 tx full", s[3:2], 2'b01);
        wr(2'd2, 32'hFFFF_0000);
        rd(2'd1, 1'b0, s);
        check("R10 tx overflow", s[6], 1'b1);
        burst("b32x32 R2", 32, 32, 1'b0, 2'd0, 2'd0, 4'b0010, 1'b1, 1'b1);
        ack();
        rd(2'd1, 1'b0, s);
        check("R10 rx full tx empty", {s[5:4], s[3]}, 3'b011);

        // R11: TX empty and RX full: zero word shifted, arriving word dropped
        burst("b8x1 R11", 8, 1, 1'b0, 2'd0, 2'd0, 4'b0000, 1'b1, 1'b1);
        ack();
        rd(2'd1, 1'b0, s);
        check("R11 tx underflow rx overflow", s[8:7], 2'b11);
        drain("b32x32 R11 data kept");

        // R11 rx underflow
        rd(2'd3, 1'b1, d);
        check("R11 empty read value", d, 32'h0);
        rd(2'd1, 1'b0, s);
        check("R11 rx underflow", s[9], 1'b1);

        // R9 flushes clear sticky flags
        wr(2'd1, 32'h400);
        rd(2'd1, 1'b0, s);
        check("R9 tx flush clears", {s[9:8], s[7:6]}, 4'b1100);
        wr(2'd1, 32'h800);
        rd(2'd1, 1'b0, s);
        check("R9 rx flush clears", s, 32'h28);

        // R11 starved transmit gives zero word: received all ones
        expq.push_back(mask_of(8));
        burst("b8x1 starve R11", 8, 1, 1'b0, 2'd0, 2'd0, 4'b0000, 1'b1, 1'b1);
        ack();
        drain("R11 zero word shifted");
        wr(2'd1, 32'h400);

        // R7 transmit disabled: zeros shifted, TX FIFO untouched
        load_tx(2, 5, 32'h1357_9BDF, 1'b0);
        expq.push_back(mask_of(5));
        expq.push_back(mask_of(5));
        burst("b5x2 R7 tx off", 5, 2, 1'b0, 2'd1, 2'd1, 4'b0000, 1'b0, 1'b1);
        ack();
        rd(2'd1, 1'b0, s);
        check("R7 tx fifo untouched", {s[3], s[7]}, 2'b00);
        drain("R7 idle data");
        wr(2'd1, 32'h400);
        rd(2'd1, 1'b0, s);
        check("R9 tx flush empties", s[3], 1'b1);

        // R7 receive disabled
        load_tx(3, 16, 32'h2468_ACE0, 1'b0);
        burst("b16x3 R7 rx off", 16, 3, 1'b1, 2'd0, 2'd0, 4'b0000, 1'b1, 1'b0);
        ack();
        rd(2'd1, 1'b0, s);
        check("R7 rx stays empty", {s[5], s[3]}, 2'b11);

        // R8 go ignored while busy
        load_tx(2, 8, 32'h7777_1111, 1'b1);
        cur_idle = 1'b0; cur_phase = 1'b0;
        wr(2'd0, mk_ctrl(8, 2, 1'b0, 2'd0, 2'd0, 4'b0000, 1'b1, 1'b1, 1'b1));
        wr(2'd0, mk_ctrl(8, 2, 1'b0, 2'd0, 2'd0, 4'b0000, 1'b1, 1'b1, 1'b1));
        wait_ready();
        ack();
        rd(2'd1, 1'b0, s);
        check("R8 second go ignored", s[0], 1'b0);
        drain("R8 data");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R8 actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule